// File: doc/BRIEF.md
# Accumulator ALU with Flag Store

This block is the arithmetic and logic unit of an 8-bit accumulator machine. One operand is always the accumulator value. The other arrives on a single data-bus input, whatever its origin (immediate, register or memory). An operation is chosen from one of two groups of eight codes: binary operators that combine accumulator and bus, and single-operand operators that work on the accumulator alone or on the carry. The result path is purely combinational. A four-bit flag store holds sign (S), zero (Z), signed overflow (V) and carry (C) and is written only on a clock edge.

For each operation the block reports the result and a result write-enable, so that the surrounding sequencer knows whether the accumulator is to be written. It also reports a per-flag update mask and the complete next flag value. Flags that an operation leaves undefined are not written and keep their previous value, so behaviour is fully deterministic. The current carry is taken from the block's own flag store. The block accepts one operation per cycle through `op_valid` and never stalls, so it has no back-pressure. A cycle with `op_valid` low writes nothing.

Top module: `acc_alu`

## Requirements
- R1: With `grp_sel`=0, code 000 gives acc+bus and code 001 gives acc+bus+C. Both write the result and all four flags. C is the unsigned carry out of bit 7, and V is set when two operands of equal sign give a result of the other sign.
- R2: With `grp_sel`=0, code 010 gives acc-bus and code 011 gives acc-bus-C. Both write the result and all four flags. C is set on a borrow (acc < bus + borrow-in), and V is set when the operand signs differ and the result sign differs from acc.
- R3: With `grp_sel`=0, code 111 (compare) sets all four flags exactly as code 010 would, with `res_we`=0.
- R4: With `grp_sel`=0, codes 100, 101 and 110 give AND, OR and XOR. They write the result, update only S and Z (`flag_mask`=4'b1100), and leave V and C unchanged.
- R5: With `grp_sel`=1, the shift codes shift acc right by one and update S, Z and C, with C taking the old bit 0 and V unchanged. Code 001 moves old C into bit 7, code 010 puts 0 into bit 7, and code 011 keeps bit 7.
- R6: With `grp_sel`=1, code 100 gives ~acc with V=0 and C=0. Code 101 gives 0-acc, with C=1 unless acc is 0 and V=1 exactly when acc is 8'h80. Both write the result and all four flags.
- R7: With `grp_sel`=1, code 110 clears C and code 111 sets C. Both have `res_we`=0 and `flag_mask`=4'b0001, and S, Z and V stay as they were.
- R8: With `grp_sel`=1, code 000 is reserved. It gives `res_we`=0 and `flag_mask`=0, and the stored flags do not change.
- R9: Whenever S or Z is updated, S equals bit 7 of the result and Z is 1 exactly when the result is zero.
- R10: With `op_valid`=0, `res_we`=0 and `flag_mask`=0, and the stored flags hold.
- R11: A synchronous reset clears all flags. Otherwise `flags_q` takes the value of `flags_next` at every rising edge. Flag bit order is {S,Z,V,C} on [3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| op_valid | input | 1 | An operation is presented this cycle |
| grp_sel | input | 1 | 0 selects the binary group, 1 the single-operand group |
| bin_op | input | 3 | Binary operator code |
| un_op | input | 3 | Single-operand operator code |
| acc_in | input | 8 | Accumulator value |
| bus_in | input | 8 | Second operand from the data bus |
| result | output | 8 | Operation result |
| res_we | output | 1 | The accumulator should take `result` |
| flag_mask | output | 4 | Flags written by this operation, {S,Z,V,C} |
| flags_next | output | 4 | Flag value after this cycle's edge |
| flags_q | output | 4 | Stored flags, {S,Z,V,C} |

## Verification
The bench builds the block with its default width of 8. At that width, exhaustive-style corner operands are easy to hit: 8'h7F, 8'h80, 8'hFF and 0, together with both carry states, reach every overflow, borrow and wrap boundary. Random operations are mixed with directed cases. Because the carry the bench models is always the one stored by the previous operation, chains of adc, sbc and rcr check that carry passes correctly between operations.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int FLAG_N = 4;
  localparam int FS = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;

  typedef enum logic [2:0] {
    B_ADD = 3'b000, B_ADC = 3'b001, B_SUB = 3'b010, B_SBC = 3'b011,
    B_AND = 3'b100, B_OR  = 3'b101, B_XOR = 3'b110, B_CMP = 3'b111
  } bin_op_e;

  typedef enum logic [2:0] {
    U_RSV = 3'b000, U_RCR = 3'b001, U_SHR = 3'b010, U_SAR = 3'b011,
    U_NOT = 3'b100, U_NEG = 3'b101, U_CLC = 3'b110, U_STC = 3'b111
  } un_op_e;

  localparam logic [FLAG_N-1:0] M_ALL  = 4'b1111;
  localparam logic [FLAG_N-1:0] M_SZ   = 4'b1100;
  localparam logic [FLAG_N-1:0] M_SZC  = 4'b1101;
  localparam logic [FLAG_N-1:0] M_C    = 4'b0001;
  localparam logic [FLAG_N-1:0] M_NONE = 4'b0000;
endpackage

// File: rtl/acc_alu_binop.sv
module acc_alu_binop
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic [2:0]        op,
  output logic [DATA_W-1:0] res,
  output logic [FLAG_N-1:0] flg,
  output logic [FLAG_N-1:0] msk,
  output logic              we
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] sum_w;
  logic [DATA_W:0] dif_w;
  logic            add_ci;
  logic            sub_bi;
  logic            v_add;
  logic            v_sub;
  bin_op_e         opc;

  assign opc    = bin_op_e'(op);
  assign add_ci = (opc == B_ADC) ? cin : 1'b0;
  assign sub_bi = (opc == B_SBC) ? cin : 1'b0;
  assign sum_w  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, add_ci};
  assign dif_w  = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, sub_bi};
  assign v_add  = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
  assign v_sub  = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);

  always_comb begin
    res = '0;
    flg = '0;
    msk = M_NONE;
    we  = 1'b1;
    unique case (opc)
      B_ADD, B_ADC: begin
        res     = sum_w[MSB:0];
        flg[FC] = sum_w[DATA_W];
        flg[FV] = v_add;
        msk     = M_ALL;
      end
      B_SUB, B_SBC, B_CMP: begin
        res     = dif_w[MSB:0];
        flg[FC] = dif_w[DATA_W];
        flg[FV] = v_sub;
        msk     = M_ALL;
        we      = (opc != B_CMP);
      end
      B_AND: begin res = a & b; msk = M_SZ; end
      B_OR:  begin res = a | b; msk = M_SZ; end
      B_XOR: begin res = a ^ b; msk = M_SZ; end
      default: begin res = '0; msk = M_NONE; we = 1'b0; end
    endcase
    flg[FS] = res[MSB];
    flg[FZ] = (res == '0);
  end
endmodule

// File: rtl/acc_alu_unop.sv
module acc_alu_unop
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  input  logic [2:0]        op,
  output logic [DATA_W-1:0] res,
  output logic [FLAG_N-1:0] flg,
  output logic [FLAG_N-1:0] msk,
  output logic              we
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] neg_v;
  un_op_e            opc;

  assign opc   = un_op_e'(op);
  assign neg_v = '0 - a;

  always_comb begin
    res = '0;
    flg = '0;
    msk = M_NONE;
    we  = 1'b0;
    unique case (opc)
      U_RCR: begin res = {cin, a[MSB:1]};    flg[FC] = a[0]; msk = M_SZC; we = 1'b1; end
      U_SHR: begin res = {1'b0, a[MSB:1]};   flg[FC] = a[0]; msk = M_SZC; we = 1'b1; end
      U_SAR: begin res = {a[MSB], a[MSB:1]}; flg[FC] = a[0]; msk = M_SZC; we = 1'b1; end
      U_NOT: begin res = ~a; msk = M_ALL; we = 1'b1; end
      U_NEG: begin
        res     = neg_v;
        flg[FC] = (a != '0);
        flg[FV] = (a == MIN_NEG);
        msk     = M_ALL;
        we      = 1'b1;
      end
      U_CLC: begin flg[FC] = 1'b0; msk = M_C; end
      U_STC: begin flg[FC] = 1'b1; msk = M_C; end
      default: begin msk = M_NONE; we = 1'b0; end
    endcase
    flg[FS] = res[MSB];
    flg[FZ] = (res == '0);
  end
endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_N-1:0] upd,
  input  logic [FLAG_N-1:0] d,
  output logic [FLAG_N-1:0] q
);
  for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)          q[gi] <= 1'b0;
      else if (upd[gi]) q[gi] <= d[gi];
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !upd[gi] |=> q[gi] == $past(q[gi])); // R11
    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
      upd[gi] |=> q[gi] == $past(d[gi])); // R11
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> q == '0); // R11
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              grp_sel,
  input  logic [2:0]        bin_op,
  input  logic [2:0]        un_op,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] result,
  output logic              res_we,
  output logic [FLAG_N-1:0] flag_mask,
  output logic [FLAG_N-1:0] flags_next,
  output logic [FLAG_N-1:0] flags_q
);
  logic [DATA_W-1:0] b_res, u_res;
  logic [FLAG_N-1:0] b_flg, u_flg, b_msk, u_msk, sel_flg;
  logic              b_we, u_we;

  acc_alu_binop #(.DATA_W(DATA_W)) u_bin (
    .a(acc_in), .b(bus_in), .cin(flags_q[FC]), .op(bin_op),
    .res(b_res), .flg(b_flg), .msk(b_msk), .we(b_we)
  );

  acc_alu_unop #(.DATA_W(DATA_W)) u_un (
    .a(acc_in), .cin(flags_q[FC]), .op(un_op),
    .res(u_res), .flg(u_flg), .msk(u_msk), .we(u_we)
  );

  assign result     = grp_sel ? u_res : b_res;
  assign sel_flg    = grp_sel ? u_flg : b_flg;
  assign flag_mask  = op_valid ? (grp_sel ? u_msk : b_msk) : M_NONE;
  assign res_we     = op_valid && (grp_sel ? u_we : b_we);
  assign flags_next = (sel_flg & flag_mask) | (flags_q & ~flag_mask);

  acc_alu_flagreg u_flags (
    .clk(clk), .rst(rst), .upd(flag_mask), .d(flags_next), .q(flags_q)
  );

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !grp_sel && bin_op == 3'b111) |-> (!res_we && flag_mask == M_ALL)); // R3
  AST_CARRY_ONLY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && grp_sel && un_op[2:1] == 2'b11) |-> (!res_we && flag_mask == M_C)); // R7
  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && grp_sel && un_op == 3'b000) |=> $stable(flags_q)); // R8
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(flags_q)); // R10
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    flag_mask[FZ] |-> (flags_next[FZ] == (result == '0))); // R9
  AST_LOGIC_KEEPS_VC: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !grp_sel && bin_op[2] && bin_op != 3'b111) |=> $stable(flags_q[FV:FC])); // R4
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic       grp_sel = 1'b0;
  logic [2:0] bin_op = '0;
  logic [2:0] un_op = '0;
  logic [7:0] acc_in = '0;
  logic [7:0] bus_in = '0;
  logic [7:0] result;
  logic       res_we;
  logic [3:0] flag_mask;
  logic [3:0] flags_next;
  logic [3:0] flags_q;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] fm = '0;
  bit done = 0;

  always #4 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .grp_sel(grp_sel),
    .bin_op(bin_op), .un_op(un_op), .acc_in(acc_in), .bus_in(bus_in),
    .result(result), .res_we(res_we), .flag_mask(flag_mask),
    .flags_next(flags_next), .flags_q(flags_q)
  );

  function automatic string tag_of(logic v, logic s, logic [2:0] b, logic [2:0] u);
    if (!v) return "R10";
    if (!s) begin
      case (b)
        3'd0, 3'd1: return "R1";
        3'd2, 3'd3: return "R2";
        3'd7:       return "R3";
        default:    return "R4";
      endcase
    end
    case (u)
      3'd0:       return "R8";
      3'd4, 3'd5: return "R6";
      3'd6, 3'd7: return "R7";
      default:    return "R5";
    endcase
  endfunction

  // returns {we, mask[3:0], next flags[3:0], result[7:0]}
  function automatic logic [16:0] model(logic v, logic s, logic [2:0] b, logic [2:0] u,
                                        logic [7:0] a8, logic [7:0] d8, logic [3:0] fl);
    int ai = int'(a8);
    int bi = int'(d8);
    int c = int'(fl[0]);
    int sa = (ai >= 128) ? ai - 256 : ai;
    int sb = (bi >= 128) ? bi - 256 : bi;
    int r = 0, t, sv, cc;
    logic we = 0;
    logic [3:0] m = 4'b0000;
    logic [3:0] nf = fl;
    if (v) begin
      if (!s) begin
        we = (b != 3'd7);
        case (b)
          3'd0, 3'd1: begin
            cc = (b == 3'd1) ? c : 0;
            t = ai + bi + cc; sv = sa + sb + cc;
            r = t & 255; m = 4'b1111;
            nf[0] = (t > 255); nf[1] = (sv > 127 || sv < -128);
          end
          3'd2, 3'd3, 3'd7: begin
            cc = (b == 3'd3) ? c : 0;
            t = ai - bi - cc; sv = sa - sb - cc;
            r = t & 255; m = 4'b1111;
            nf[0] = (t < 0); nf[1] = (sv > 127 || sv < -128);
          end
          3'd4: begin r = ai & bi; m = 4'b1100; end
          3'd5: begin r = ai | bi; m = 4'b1100; end
          default: begin r = ai ^ bi; m = 4'b1100; end
        endcase
      end else begin
        case (u)
          3'd1: begin r = (c * 128) + (ai / 2); nf[0] = ai[0]; m = 4'b1101; we = 1; end
          3'd2: begin r = ai / 2; nf[0] = ai[0]; m = 4'b1101; we = 1; end
          3'd3: begin r = (ai & 128) + (ai / 2); nf[0] = ai[0]; m = 4'b1101; we = 1; end
          3'd4: begin r = 255 - ai; nf[1] = 0; nf[0] = 0; m = 4'b1111; we = 1; end
          3'd5: begin
            r = (256 - ai) & 255; sv = -sa;
            nf[1] = (sv > 127); nf[0] = (ai != 0); m = 4'b1111; we = 1;
          end
          3'd6: begin nf[0] = 0; m = 4'b0001; end
          3'd7: begin nf[0] = 1; m = 4'b0001; end
          default: ;
        endcase
      end
      if (m[3]) begin
        nf[3] = (r >= 128);   // R9
        nf[2] = (r == 0);     // R9
      end
    end
    return {we, m, nf, 8'(r)};
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(logic v, logic s, logic [2:0] b, logic [2:0] u,
                        logic [7:0] a8, logic [7:0] d8);
    logic [16:0] e;
    string tg;
    @(negedge clk);
    op_valid = v; grp_sel = s; bin_op = b; un_op = u; acc_in = a8; bus_in = d8;
    e = model(v, s, b, u, a8, d8, fm);
    tg = tag_of(v, s, b, u);
    #2;
    chk(tg, "res_we", int'(res_we), int'(e[16]));
    chk(tg, "flag_mask", int'(flag_mask), int'(e[15:12]));
    chk(tg, "flags_next", int'(flags_next), int'(e[11:8]));
    if (e[16]) chk(tg, "result", int'(result), int'(e[7:0]));
    @(posedge clk);
    #1;
    chk("R11", "flags_q", int'(flags_q), int'(e[11:8]));
    fm = e[11:8];
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset flags_q", int'(flags_q), 0);
    @(negedge clk);
    rst = 1'b0;
    fm = 4'b0000;

    // directed corners
    run_op(1, 0, 3'd0, 3'd0, 8'h7F, 8'h01);  // R1 signed overflow
    run_op(1, 0, 3'd0, 3'd0, 8'hFF, 8'h01);  // R1 wrap to zero, carry
    run_op(1, 0, 3'd1, 3'd0, 8'hFF, 8'h00);  // R1 adc with carry in
    run_op(1, 0, 3'd2, 3'd0, 8'h00, 8'h01);  // R2 borrow
    run_op(1, 0, 3'd3, 3'd0, 8'h80, 8'h00);  // R2 sbc borrow-in, overflow
    run_op(1, 0, 3'd7, 3'd0, 8'h10, 8'h20);  // R3 compare
    run_op(1, 0, 3'd4, 3'd0, 8'hF0, 8'h0F);  // R4 and -> zero, V/C kept
    run_op(1, 0, 3'd6, 3'd0, 8'hAA, 8'h55);  // R4 xor
    run_op(1, 1, 3'd0, 3'd7, 8'h00, 8'h00);  // R7 stc
    run_op(1, 1, 3'd0, 3'd1, 8'h02, 8'h00);  // R5 rcr with C=1
    run_op(1, 1, 3'd0, 3'd3, 8'h81, 8'h00);  // R5 sar
    run_op(1, 1, 3'd0, 3'd2, 8'h81, 8'h00);  // R5 shr
    run_op(1, 1, 3'd0, 3'd5, 8'h80, 8'h00);  // R6 neg of min
    run_op(1, 1, 3'd0, 3'd5, 8'h00, 8'h00);  // R6 neg of zero
    run_op(1, 1, 3'd0, 3'd4, 8'hFF, 8'h00);  // R6 not -> zero
    run_op(1, 1, 3'd0, 3'd0, 8'h00, 8'h00);  // R8 reserved
    run_op(1, 1, 3'd0, 3'd6, 8'h00, 8'h00);  // R7 clc
    run_op(0, 0, 3'd0, 3'd0, 8'hFF, 8'hFF);  // R10 idle

    for (int k = 0; k < 3000; k++) begin
      logic [7:0] ra, rb;
      int pick;
      pick = $urandom_range(0, 7);
      ra = 8'($urandom);
      rb = 8'($urandom);
      if (pick == 0) ra = 8'h80;
      if (pick == 1) rb = 8'h7F;
      if (pick == 2) ra = 8'h00;
      run_op(($urandom_range(0, 9) != 0), 1'($urandom), 3'($urandom), 3'($urandom), ra, rb);
    end

    // reset in the middle clears flags
    run_op(1, 1, 3'd0, 3'd7, 8'h00, 8'h00);
    @(negedge clk);
    rst = 1'b1;
    op_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R11", "mid reset flags_q", int'(flags_q), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule